// File: doc/BRIEF.md
# Gated Output Strobe Decoder

This block turns a short output address into one of six active-low timing strobes for a display controller. An input-sequence pulse captures the low bits of the wider input bus into a small address register. The register holds that code until the next pulse. The code is then decoded against two separate timing feeds. The edge feed times the clock-type strobes: control register, start and input-address register. The RAM feed times the memory writes: horizontal control, odd buffer and even buffer.

No strobe can fire unless the output-me flag is high. The flag comes from address-matching logic outside this block. The buffer code behaves differently on each feed. Under the edge feed it loads the input-address register. Under the RAM feed it writes a line buffer, and the even-line input chooses which buffer. Both feeds may be active together, and each one then acts on its own strobe group.

The strobe outputs are combinational from the held code, the flag, the feeds and the even-line input. A strobe therefore follows the feed pulse that gates it.

Top module: `osd_strobe_decoder`

## Requirements
- R1: After reset the address register holds all ones (code 15, unlisted), so strobeN reads 6'b111111 under any flag and feed values until a code is loaded.
- R2: A high inSeqPulse at a rising clock edge loads inBus[3:0] into the address register. Bits inBus[7:4] have no effect on any strobe.
- R3: Without inSeqPulse the address register keeps its value, whatever inBus does.
- R4: With edgeFeed and ramFeed both low, strobeN reads 6'b111111.
- R5: With outMe low, strobeN reads 6'b111111 for any code and any feed.
- R6: strobeN bit 5 is the control-register clock, bit 4 start, bit 3 input-address-register clock, bit 2 horizontal-control write, bit 1 odd-buffer write and bit 0 even-buffer write. Code 0 with outMe and edgeFeed high gives 6'b011111.
- R7: Code 1 with outMe and edgeFeed high gives 6'b101111.
- R8: Code 3 with outMe and edgeFeed high gives 6'b110111.
- R9: Code 8 with outMe and edgeFeed high gives the input-address-register load, 6'b110111.
- R10: Code 2 with outMe and ramFeed high gives 6'b111011.
- R11: Code 8 with outMe and ramFeed high gives 6'b111101 when evenLine is 1 and 6'b111110 when evenLine is 0.
- R12: A code with no function on a feed asserts nothing from that feed's group. Codes 4-7 and 9-15 assert nothing under either feed. Code 2 asserts nothing under the edge feed. Codes 0, 1 and 3 assert nothing under the RAM feed.
- R13: The two feeds act independently. With both high, each group decodes on its own and no group asserts more than one strobe. For example, code 8 gives 6'b110101 (evenLine 1) or 6'b110110 (evenLine 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inBus | input | 8 | Input address bus; its low 4 bits are the output address |
| inSeqPulse | input | 1 | Loads the output address register |
| outMe | input | 1 | Output-me flag; gates every strobe |
| edgeFeed | input | 1 | Timing enable for the clock-type strobes |
| ramFeed | input | 1 | Timing enable for the memory-write strobes |
| evenLine | input | 1 | Selects the odd (1) or even (0) buffer write |
| strobeN | output | 6 | Active-low strobes, bit order as in R6 |

## Verification
The bench builds the block with its default parameters: a 4-bit address taken from an 8-bit bus, with the buffer code at 8. With these values all sixteen codes can be swept exhaustively under every combination of flag, feeds and even-line. The four upper bus bits give random stimulus a real path for showing that they are ignored. Random loads, and bus changes without a load, check capture and hold through the strobes alone.

// File: rtl/osd_pkg.sv
package osd_pkg;

  // Active-high strobe set. The first member is the MSB of the packed form,
  // which fixes the output bit order (control register first, even buffer last).
  typedef struct packed {
    logic ctrlClk;
    logic startClk;
    logic iarClk;
    logic horWr;
    logic oddWr;
    logic evenWr;
  } strobe_t;

  localparam int NUM_STROBES = $bits(strobe_t);

endpackage

// File: rtl/osd_control.sv
module osd_control
  import osd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CODE_CTRL  = 0,
  parameter int CODE_START = 1,
  parameter int CODE_HOR   = 2,
  parameter int CODE_IAR   = 3,
  parameter int CODE_BUF   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              outMe,
  input  logic              edgeFeed,
  input  logic              ramFeed,
  input  logic              evenLine,
  output strobe_t           strobes
);

  localparam logic [ADDR_W-1:0] C_CTRL  = ADDR_W'(CODE_CTRL);
  localparam logic [ADDR_W-1:0] C_START = ADDR_W'(CODE_START);
  localparam logic [ADDR_W-1:0] C_HOR   = ADDR_W'(CODE_HOR);
  localparam logic [ADDR_W-1:0] C_IAR   = ADDR_W'(CODE_IAR);
  localparam logic [ADDR_W-1:0] C_BUF   = ADDR_W'(CODE_BUF);

  logic edgeGate;
  logic ramGate;
  logic isCtrl, isStart, isHor, isIar, isBuf;

  always_comb begin
    isCtrl  = (addr == C_CTRL);
    isStart = (addr == C_START);
    isHor   = (addr == C_HOR);
    isIar   = (addr == C_IAR);
    isBuf   = (addr == C_BUF);
  end

  assign edgeGate = outMe & edgeFeed;
  assign ramGate  = outMe & ramFeed;

  // Edge group: on the edge feed the buffer code doubles as the IAR load.
  always_comb begin
    strobes.ctrlClk  = edgeGate & isCtrl;
    strobes.startClk = edgeGate & isStart;
    strobes.iarClk   = edgeGate & (isIar | isBuf);
  end

  // RAM group: evenLine steers the buffer write.
  always_comb begin
    strobes.horWr  = ramGate & isHor;
    strobes.oddWr  = ramGate & isBuf & evenLine;
    strobes.evenWr = ramGate & isBuf & ~evenLine;
  end

  // R5: flag low keeps every strobe quiet
  p_flag_gates_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !outMe |-> (strobes == '0));

  // R4: each feed owns its group
  p_edge_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !edgeFeed |-> !(strobes.ctrlClk | strobes.startClk | strobes.iarClk));

  p_ram_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ramFeed |-> !(strobes.horWr | strobes.oddWr | strobes.evenWr));

  // R13: at most one strobe per group
  p_edge_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.ctrlClk, strobes.startClk, strobes.iarClk}));

  p_ram_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.horWr, strobes.oddWr, strobes.evenWr}));

endmodule

// File: rtl/osd_datapath.sv
module osd_datapath
  import osd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BUS_W-1:0]       inBus,
  input  logic                   inSeqPulse,
  input  strobe_t                strobes,
  output logic [ADDR_W-1:0]      addrQ,
  output logic [NUM_STROBES-1:0] strobeN
);

  localparam logic [ADDR_W-1:0] RESET_CODE = '1;

  logic [ADDR_W-1:0] busLow;
  assign busLow = inBus[ADDR_W-1:0];

  generate
    if (BUS_W > ADDR_W) begin : g_hi
      logic unusedBusHi;
      assign unusedBusHi = ^inBus[BUS_W-1:ADDR_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addrQ <= RESET_CODE;
    else if (inSeqPulse) addrQ <= busLow;
  end

  assign strobeN = ~strobes;

  // R2: capture on the pulse
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inSeqPulse |=> (addrQ == $past(busLow)));

  // R3: hold without the pulse
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inSeqPulse |=> $stable(addrQ));

endmodule

// File: rtl/osd_strobe_decoder.sv
module osd_strobe_decoder
  import osd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BUS_W      = 8,
  parameter int CODE_CTRL  = 0,
  parameter int CODE_START = 1,
  parameter int CODE_HOR   = 2,
  parameter int CODE_IAR   = 3,
  parameter int CODE_BUF   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] inBus,
  input  logic             inSeqPulse,
  input  logic             outMe,
  input  logic             edgeFeed,
  input  logic             ramFeed,
  input  logic             evenLine,
  output logic [5:0]       strobeN
);

  logic [ADDR_W-1:0]      addrQ;
  strobe_t                strobes;
  logic [NUM_STROBES-1:0] strobeVec;

  osd_datapath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .inBus(inBus), .inSeqPulse(inSeqPulse),
    .strobes(strobes), .addrQ(addrQ), .strobeN(strobeVec)
  );

  osd_control #(
    .ADDR_W(ADDR_W), .CODE_CTRL(CODE_CTRL), .CODE_START(CODE_START),
    .CODE_HOR(CODE_HOR), .CODE_IAR(CODE_IAR), .CODE_BUF(CODE_BUF)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .addr(addrQ), .outMe(outMe),
    .edgeFeed(edgeFeed), .ramFeed(ramFeed), .evenLine(evenLine),
    .strobes(strobes)
  );

  assign strobeN = strobeVec;

endmodule

// File: tb/osd_strobe_decoder_tb.sv
module osd_strobe_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inBus = '0;
  logic       inSeqPulse = 1'b0;
  logic       outMe = 1'b0;
  logic       edgeFeed = 1'b0;
  logic       ramFeed = 1'b0;
  logic       evenLine = 1'b0;
  logic [5:0] strobeN;

  int checks = 0;
  int errors = 0;
  logic [3:0] modelAddr;

  always #10 clk = ~clk;

  osd_strobe_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .inBus(inBus), .inSeqPulse(inSeqPulse),
    .outMe(outMe), .edgeFeed(edgeFeed), .ramFeed(ramFeed),
    .evenLine(evenLine), .strobeN(strobeN)
  );

  function automatic logic [5:0] expStrobe(input logic [3:0] a, input logic me,
                                           input logic ef, input logic rf,
                                           input logic ev);
    logic [5:0] act = '0; // active-high, bit 5 ctrl ... bit 0 even
    if (me && ef) begin
      if (a == 4'd0) act[5] = 1'b1;
      if (a == 4'd1) act[4] = 1'b1;
      if (a == 4'd3 || a == 4'd8) act[3] = 1'b1;
    end
    if (me && rf) begin
      if (a == 4'd2) act[2] = 1'b1;
      if (a == 4'd8) begin
        if (ev) act[1] = 1'b1;
        else    act[0] = 1'b1;
      end
    end
    return ~act;
  endfunction

  function automatic string reqOf(input logic [3:0] a, input logic me,
                                  input logic ef, input logic rf, input logic ev);
    if (!me) return "R5";
    if (!ef && !rf) return "R4";
    if (ef && rf) return "R13";
    if (ef) begin
      case (a)
        4'd0: return "R6";
        4'd1: return "R7";
        4'd3: return "R8";
        4'd8: return "R9";
        default: return "R12";
      endcase
    end
    if (a == 4'd2) return "R10";
    if (a == 4'd8) return (ev ? "R11" : "R11");
    return "R12";
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: strobeN actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic loadAddr(input logic [7:0] b);
    @(negedge clk);
    inBus = b; inSeqPulse = 1'b1;
    @(negedge clk);
    inSeqPulse = 1'b0;
    modelAddr = b[3:0];
  endtask

  task automatic applyCheck(input string req, input logic me, input logic ef,
                            input logic rf, input logic ev);
    outMe = me; edgeFeed = ef; ramFeed = rf; evenLine = ev;
    #1;
    check(req, strobeN, expStrobe(modelAddr, me, ef, rf, ev));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelAddr = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset code is unlisted, all feeds on still quiet
    applyCheck("R1", 1'b1, 1'b1, 1'b1, 1'b1);
    check("R1", strobeN, 6'b111111);

    // Directed codes
    loadAddr(8'h00); applyCheck("R6", 1, 1, 0, 0); check("R6", strobeN, 6'b011111);
    loadAddr(8'h01); applyCheck("R7", 1, 1, 0, 0); check("R7", strobeN, 6'b101111);
    loadAddr(8'h03); applyCheck("R8", 1, 1, 0, 0); check("R8", strobeN, 6'b110111);
    loadAddr(8'h08); applyCheck("R9", 1, 1, 0, 1); check("R9", strobeN, 6'b110111);
    loadAddr(8'h02); applyCheck("R10", 1, 0, 1, 0); check("R10", strobeN, 6'b111011);
    applyCheck("R12", 1, 1, 0, 0); check("R12", strobeN, 6'b111111);
    loadAddr(8'h08);
    applyCheck("R11", 1, 0, 1, 1); check("R11", strobeN, 6'b111101);
    applyCheck("R11", 1, 0, 1, 0); check("R11", strobeN, 6'b111110);
    applyCheck("R13", 1, 1, 1, 1); check("R13", strobeN, 6'b110101);
    applyCheck("R13", 1, 1, 1, 0); check("R13", strobeN, 6'b110110);
    applyCheck("R5", 0, 1, 1, 1);  check("R5", strobeN, 6'b111111);
    applyCheck("R4", 1, 0, 0, 1);  check("R4", strobeN, 6'b111111);

    // R2: upper bus bits ignored (0xF0 loads code 0)
    loadAddr(8'hF0); applyCheck("R2", 1, 1, 0, 0); check("R2", strobeN, 6'b011111);

    // R3: bus changes without a pulse leave the code in place
    @(negedge clk); inBus = 8'h01;
    repeat (2) @(negedge clk);
    applyCheck("R3", 1, 1, 0, 0); check("R3", strobeN, 6'b011111);

    // Exhaustive sweep of codes and controls
    for (int a = 0; a < 16; a++) begin
      loadAddr({4'(a * 3), 4'(a)});
      for (int c = 0; c < 16; c++)
        applyCheck(reqOf(modelAddr, c[3], c[2], c[1], c[0]), c[3], c[2], c[1], c[0]);
    end

    // Constrained random with fixed seed
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b = 8'($urandom);
      logic [3:0] ctl = 4'($urandom);
      if ($urandom % 3 == 0) b[3:0] = (($urandom % 2) != 0) ? 4'd8 : 4'd2;
      if (($urandom % 2) != 0) begin
        loadAddr(b);                                   // R2
      end else begin
        @(negedge clk); inBus = b; @(negedge clk);     // R3
      end
      applyCheck(reqOf(modelAddr, ctl[3], ctl[2], ctl[1], ctl[0]),
                 ctl[3], ctl[2], ctl[1], ctl[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule